// File: doc/BRIEF.md
# Token-Steered Column Word Loader

This block fills a row of per-column 6-bit gray-level registers from one shared data bus. No address is used. A single token bit enters the block from one side and steps from column to column. Each column latches the bus word while it holds the token. The side the token comes from sets the fill order, ascending or descending. A span select either uses every column or leaves four columns unused at each end of the row.

The shift clock is divided by two inside the block. A column step happens on every second rising edge after the token is taken. Each word must therefore be valid one full edge pair behind the token. When the last active column has been written, the token leaves on the opposite side pin for one divided period, so that a neighbouring block can continue the row. A level-sensitive strobe decides what the column outputs show. While the strobe is low they follow the temporary bank. While it is high they keep their last value, so a new row can load behind a stable display.

Top module: `tok_col_loader`

## Requirements
- R1: While rst_ni is low, the token chain, the clock divider and the cascade outputs are cleared and every temporary word is 0. A reset during a load ends that load, and no column is written afterwards until a new token is accepted.
- R2: The token is sampled at a rising clock edge from tok_r_i when shr_i is 1 and from tok_l_i when shr_i is 0. It is accepted only when no load is in progress. A token seen on the unselected pin, or during a load, has no effect.
- R3: With shr_i=1 and full_span_i=1, word k (k=1..NCOL) is written to column k-1. Column i appears at col_data_o[6i+5:6i], with bit 5 as the MSB.
- R4: With shr_i=0 and full_span_i=1, word k is written to column NCOL-k, so the fill runs downward from the top column.
- R5: With full_span_i=0, only columns 4..NCOL-5 are written: ascending from 4 when shr_i=1, descending from NCOL-5 when shr_i=0. Columns 0..3 and NCOL-4..NCOL-1 keep their contents.
- R6: If the token is accepted at edge e, word k is captured at edge e+2k and at no other edge. Values present on data_i at any other edge are never stored.
- R7: The clock cycle after the last active column is written, the cascade pin on the opposite side goes high for exactly two clock cycles. That is tok_l_o when shr_i was 1 at acceptance, and tok_r_o when it was 0. The other cascade pin stays low.
- R8: While lat_i is 0, col_data_o follows the temporary bank. While lat_i is 1, col_data_o holds its value even as the bank is reloaded.
- R9: Direction and span are taken when the token is accepted. Changes of shr_i or full_span_i during a load do not alter the columns written or their order.
- R10: After the last active column is written, no column changes, whatever data_i does, until a new token is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| shr_i | input | 1 | 1: token enters right pin, ascending fill; 0: left pin, descending |
| full_span_i | input | 1 | 1: all columns; 0: skip four columns at each end |
| tok_r_i | input | 1 | Right-side token input |
| tok_l_i | input | 1 | Left-side token input |
| tok_r_o | output | 1 | Right-side cascade token output (used for descending fill) |
| tok_l_o | output | 1 | Left-side cascade token output (used for ascending fill) |
| data_i | input | 6 | Gray-level word, bit 5 MSB |
| lat_i | input | 1 | Output latch strobe: 0 transparent, 1 hold |
| col_data_o | output | 6*NCOL | Output storage bank, column i at bits 6i+5:6i |

## Verification
The hardest cases to reach from the ports are the ones where inputs move while a load is in progress. The stimulus flips direction and span in the middle of a load and raises a token on the pin that has just become the selected one. It then checks that the row still fills in its original order. Every word is surrounded by its bitwise complement in the cycle before its capture edge, so a capture one edge early or late stores a visibly wrong value. A reset is also applied partway through a load, and the bus is then toggled with no token to show that the chain stays idle.

// File: rtl/tcl_pkg.sv
package tcl_pkg;
  localparam int unsigned WORD_W    = 6;
  localparam int unsigned EDGE_SKIP = 4;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/tcl_seq.sv
module tcl_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tok_in_i,
  input  logic idle_i,
  input  logic last_hit_i,
  output logic accept_o,
  output logic step_o,
  output logic casc_o
);
  logic div_q;
  logic casc_q;
  logic casc_t_q;

  assign accept_o = tok_in_i & idle_i;
  assign step_o   = div_q;
  assign casc_o   = casc_q;

  // divider restarts on acceptance so the first step lands two edges later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= 1'b0;
    else if (accept_o) div_q <= 1'b0;
    else               div_q <= ~div_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      casc_q   <= 1'b0;
      casc_t_q <= 1'b0;
    end else if (step_o && last_hit_i) begin
      casc_q   <= 1'b1;
      casc_t_q <= 1'b0;
    end else if (casc_q) begin
      casc_t_q <= 1'b1;
      if (casc_t_q) casc_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tcl_chain.sv
module tcl_chain #(
  parameter int unsigned NCOL = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  logic            step_i,
  input  logic            dir_i,
  input  logic            full_i,
  output logic [NCOL-1:0] we_o,
  output logic            idle_o,
  output logic            last_hit_o,
  output logic            dir_q_o
);
  import tcl_pkg::*;
  localparam int unsigned IW = (NCOL > 1) ? $clog2(NCOL) : 1;

  logic [NCOL-1:0] hot_q;
  logic [NCOL-1:0] nxt_hot;
  logic            dir_q;
  logic            full_q;
  logic [IW-1:0]   first_idx;
  logic [IW-1:0]   last_idx;

  function automatic int lo_f(input logic full);
    return full ? 0 : int'(EDGE_SKIP);
  endfunction

  function automatic int hi_f(input logic full);
    return full ? int'(NCOL) - 1 : int'(NCOL) - 1 - int'(EDGE_SKIP);
  endfunction

  always_comb begin
    first_idx = IW'(dir_i ? lo_f(full_i) : hi_f(full_i));
    last_idx  = IW'(dir_q ? hi_f(full_q) : lo_f(full_q));
  end

  for (genvar i = 0; i < NCOL; i++) begin : g_nxt
    if (i == 0) begin : g_lo
      assign nxt_hot[i] = dir_q ? 1'b0 : hot_q[i+1];
    end else if (i == NCOL-1) begin : g_hi
      assign nxt_hot[i] = dir_q ? hot_q[i-1] : 1'b0;
    end else begin : g_mid
      assign nxt_hot[i] = dir_q ? hot_q[i-1] : hot_q[i+1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hot_q  <= '0;
      dir_q  <= 1'b1;
      full_q <= 1'b1;
    end else if (accept_i) begin
      hot_q  <= {{(NCOL-1){1'b0}}, 1'b1} << first_idx;
      dir_q  <= dir_i;
      full_q <= full_i;
    end else if (step_i) begin
      hot_q  <= last_hit_o ? '0 : nxt_hot;
    end
  end

  assign we_o       = step_i ? hot_q : '0;
  assign idle_o     = ~|hot_q;
  assign last_hit_o = hot_q[last_idx];
  assign dir_q_o    = dir_q;
endmodule

// File: rtl/tcl_col.sv
module tcl_col (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  tcl_pkg::word_t     d_i,
  input  logic               lat_i,
  output tcl_pkg::word_t     tmp_o,
  output tcl_pkg::word_t     out_o
);
  tcl_pkg::word_t tmp_q;
  tcl_pkg::word_t out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tmp_q <= '0;
    else if (we_i) tmp_q <= d_i;
  end

  // level-sensitive output storage: open while strobe low
  always_latch begin
    if (!lat_i) out_q <= tmp_q;
  end

  assign tmp_o = tmp_q;
  assign out_o = out_q;
endmodule

// File: rtl/tok_col_loader.sv
module tok_col_loader #(
  parameter int unsigned NCOL = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              shr_i,
  input  logic                              full_span_i,
  input  logic                              tok_r_i,
  input  logic                              tok_l_i,
  output logic                              tok_r_o,
  output logic                              tok_l_o,
  input  logic [tcl_pkg::WORD_W-1:0]        data_i,
  input  logic                              lat_i,
  output logic [NCOL*tcl_pkg::WORD_W-1:0]   col_data_o
);
  import tcl_pkg::*;
  localparam int unsigned BW = NCOL * WORD_W;

  logic            tok_in;
  logic            accept_w;
  logic            step_w;
  logic            casc_w;
  logic            idle_w;
  logic            last_hit_w;
  logic            dir_q_w;
  logic [NCOL-1:0] we_w;
  logic [BW-1:0]   tmp_flat;

  assign tok_in = shr_i ? tok_r_i : tok_l_i;

  tcl_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tok_in_i   (tok_in),
    .idle_i     (idle_w),
    .last_hit_i (last_hit_w),
    .accept_o   (accept_w),
    .step_o     (step_w),
    .casc_o     (casc_w)
  );

  tcl_chain #(.NCOL(NCOL)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept_w),
    .step_i     (step_w),
    .dir_i      (shr_i),
    .full_i     (full_span_i),
    .we_o       (we_w),
    .idle_o     (idle_w),
    .last_hit_o (last_hit_w),
    .dir_q_o    (dir_q_w)
  );

  for (genvar i = 0; i < NCOL; i++) begin : g_col
    tcl_col u_col (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we_w[i]),
      .d_i    (data_i),
      .lat_i  (lat_i),
      .tmp_o  (tmp_flat[i*WORD_W +: WORD_W]),
      .out_o  (col_data_o[i*WORD_W +: WORD_W])
    );
  end

  assign tok_l_o = casc_w &  dir_q_w;
  assign tok_r_o = casc_w & ~dir_q_w;
endmodule

// File: rtl/tok_col_loader_chk.sv
module tok_col_loader_chk #(
  parameter int unsigned NCOL = 16
) (
  input logic                                clk_i,
  input logic                                rst_ni,
  input logic                                lat_i,
  input logic [tcl_pkg::WORD_W-1:0]          data_i,
  input logic [NCOL-1:0]                     we_w,
  input logic [NCOL*tcl_pkg::WORD_W-1:0]     tmp_flat,
  input logic [NCOL*tcl_pkg::WORD_W-1:0]     col_data_o,
  input logic                                tok_l_o,
  input logic                                tok_r_o
);
  localparam int unsigned W = tcl_pkg::WORD_W;
  logic tok_any;
  assign tok_any = tok_l_o | tok_r_o;

  a_r6_one_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_w));

  a_r6_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|we_w) |=> !(|we_w));

  for (genvar i = 0; i < NCOL; i++) begin : g_cap
    a_r6_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_w[i] |=> tmp_flat[i*W +: W] == $past(data_i));
  end

  a_r8_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lat_i |-> col_data_o == tmp_flat);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_i && $past(lat_i)) |-> $stable(col_data_o));

  a_r7_one_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tok_l_o && tok_r_o));

  a_r7_pulse_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tok_any) |=> tok_any);

  a_r7_pulse_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_any && $past(tok_any)) |=> !tok_any);
endmodule

bind tok_col_loader tok_col_loader_chk #(.NCOL(NCOL)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lat_i      (lat_i),
  .data_i     (data_i),
  .we_w       (we_w),
  .tmp_flat   (tmp_flat),
  .col_data_o (col_data_o),
  .tok_l_o    (tok_l_o),
  .tok_r_o    (tok_r_o)
);

// File: tb/tok_col_loader_tb_top.sv
module tok_col_loader_tb_top;
  localparam int NCOL = 16;
  localparam int W    = 6;
  localparam int SKIP = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic shr_i = 1'b1, full_span_i = 1'b1, tok_r_i = 1'b0, tok_l_i = 1'b0, lat_i = 1'b0;
  logic tok_r_o, tok_l_o;
  logic [W-1:0] data_i = '0;
  logic [NCOL*W-1:0] col_data_o;

  always #2 clk = ~clk;

  tok_col_loader #(.NCOL(NCOL)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .shr_i(shr_i), .full_span_i(full_span_i),
    .tok_r_i(tok_r_i), .tok_l_i(tok_l_i), .tok_r_o(tok_r_o), .tok_l_o(tok_l_o),
    .data_i(data_i), .lat_i(lat_i), .col_data_o(col_data_o)
  );

  typedef struct { int col; logic [W-1:0] val; string req; } item_t;
  item_t sb_q[$];
  event  cmp_ev;
  logic [W-1:0] exp_bank [NCOL];
  logic [W-1:0] snap [NCOL];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: drains the scoreboard against the column outputs
  always @(cmp_ev) begin
    while (sb_q.size() > 0) begin
      item_t it;
      int act;
      it  = sb_q.pop_front();
      act = int'(col_data_o[it.col*W +: W]);
      chk(act == int'(it.val), $sformatf("%s col%0d", it.req, it.col), act, int'(it.val));
    end
  end

  task automatic push_vals(input logic [W-1:0] b [NCOL], input string req);
    for (int c = 0; c < NCOL; c++) sb_q.push_back('{c, b[c], req});
    -> cmp_ev;
    wait (sb_q.size() == 0);
  endtask

  task automatic wiggle(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      data_i = W'(j * 13 + 5);
    end
    @(negedge clk);
    data_i = '0;
  endtask

  // driver: one row load, word k captured two edges after the previous one
  task automatic load(input bit dir, input bit full, input int seed,
                      input string req, input bit disturb, input int stop_at);
    int lo, hi, n;
    lo = full ? 0 : SKIP;
    hi = full ? NCOL-1 : NCOL-1-SKIP;
    n  = hi - lo + 1;
    @(negedge clk);
    shr_i = dir; full_span_i = full; data_i = '0;
    if (dir) tok_r_i = 1'b1; else tok_l_i = 1'b1;
    @(negedge clk);
    tok_r_i = 1'b0; tok_l_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] w;
      if (k == stop_at) return;
      w = W'(seed + k * 11);
      data_i = ~w;
      @(negedge clk);
      data_i = w;
      if (disturb && k == 2) begin
        shr_i = ~dir; full_span_i = ~full;
        if (!dir) tok_r_i = 1'b1; else tok_l_i = 1'b1;
      end
      @(negedge clk);
      tok_r_i = 1'b0; tok_l_i = 1'b0;
      exp_bank[dir ? lo + k : hi - k] = w;
    end
    shr_i = dir; full_span_i = full; data_i = '0;
    chk((dir ? tok_l_o : tok_r_o) == 1'b1, {req, " R7 cascade c1"}, int'(dir ? tok_l_o : tok_r_o), 1);
    chk((dir ? tok_r_o : tok_l_o) == 1'b0, {req, " R7 idle side"}, int'(dir ? tok_r_o : tok_l_o), 0);
    @(negedge clk);
    chk((dir ? tok_l_o : tok_r_o) == 1'b1, {req, " R7 cascade c2"}, int'(dir ? tok_l_o : tok_r_o), 1);
    @(negedge clk);
    chk({tok_l_o, tok_r_o} == 2'b00, {req, " R7 cascade end"}, int'({tok_l_o, tok_r_o}), 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCOL; c++) exp_bank[c] = '0;
    repeat (3) @(negedge clk);
    chk({tok_l_o, tok_r_o} == 2'b00, "R1 tok outs in reset", int'({tok_l_o, tok_r_o}), 0);
    push_vals(exp_bank, "R1 reset bank");
    rst_ni = 1'b1;
    @(negedge clk);

    load(1'b1, 1'b1, 5, "R3 R6", 1'b0, -1);
    push_vals(exp_bank, "R3 R6 ascending");

    lat_i = 1'b1;
    snap = exp_bank;
    load(1'b0, 1'b1, 20, "R4", 1'b0, -1);
    push_vals(snap, "R8 hold while loading");
    lat_i = 1'b0;
    @(negedge clk);
    push_vals(exp_bank, "R4 R8 descending after open");

    load(1'b1, 1'b0, 33, "R5 asc", 1'b0, -1);
    push_vals(exp_bank, "R5 span asc");
    load(1'b0, 1'b0, 47, "R5 desc", 1'b0, -1);
    push_vals(exp_bank, "R5 span desc");

    load(1'b1, 1'b1, 9, "R9", 1'b1, -1);
    push_vals(exp_bank, "R9 R2 mid-load flip and token");

    @(negedge clk);
    shr_i = 1'b1; tok_l_i = 1'b1;
    @(negedge clk);
    tok_l_i = 1'b0;
    wiggle(20);
    chk({tok_l_o, tok_r_o} == 2'b00, "R2 wrong pin no cascade", int'({tok_l_o, tok_r_o}), 0);
    push_vals(exp_bank, "R2 wrong pin ignored");

    wiggle(12);
    push_vals(exp_bank, "R10 no token no write");

    load(1'b0, 1'b1, 3, "R1", 1'b0, 5);
    rst_ni = 1'b0;
    for (int c = 0; c < NCOL; c++) exp_bank[c] = '0;
    @(negedge clk);
    chk({tok_l_o, tok_r_o} == 2'b00, "R1 mid-load reset outs", int'({tok_l_o, tok_r_o}), 0);
    push_vals(exp_bank, "R1 mid-load reset bank");
    rst_ni = 1'b1;
    wiggle(24);
    chk({tok_l_o, tok_r_o} == 2'b00, "R1 R10 no cascade after reset", int'({tok_l_o, tok_r_o}), 0);
    push_vals(exp_bank, "R1 R10 chain idle after reset");

    done = 1;
    summary();
    $finish;
  end
endmodule